// File: doc/BRIEF.md
# Encoded Interrupt Pattern Mask Unit

This block sits between two groups of 4-bit encoded level interrupt inputs and the interrupt arbiter. Each group drives a 4-bit level pattern. The value 4'hF means that no request is present, and each of the other fifteen values names a request. The block keeps one mask bit for each non-idle pattern of each group. A group's request goes on to the arbiter only if the group is in encoded mode, the group is not blocked by an upstream group mask, and the mask bit for its current pattern is clear.

Software reaches the masks through a 32-bit register bus. It uses two addresses: one that sets mask bits and one that clears them. Writing 0 to either address leaves the masks unchanged, so software can change single patterns without a read-modify-write sequence. The set address reads back the whole mask image. A read in the cycle after a write already returns the updated state, so a read-back confirms that a change has taken effect.

Top module: `irlmask_top`

## Requirements
- R1: After reset every mask bit is 0. A read of the set address returns 32'h0, and any non-idle pattern in an enabled, unblocked group is forwarded.
- R2: A write to byte address 4'h0 (set address) sets each mask bit whose write-data bit is 1. Bits written 0 keep their value.
- R3: A write to byte address 4'h4 (clear address) clears each mask bit whose write-data bit is 1. Bits written 0 keep their value. A read of the clear address always returns 32'h0.
- R4: Group 0's pattern p (0 to 14) is controlled by bit 31-p of the mask image. Group 1's pattern p is controlled by bit 15-p.
- R5: Image bits 16 and 0 always read 0 and cannot be set.
- R6: A read of the set address in the cycle right after a set or clear write returns the new mask state.
- R7: Group g's request valid is 1 exactly when its pattern is not 4'hF, its encoded-mode enable is 1, its upstream mask is 0 and its pattern's mask bit is 0. The request pattern output equals the input pattern when valid is 1 and is 4'hF otherwise.
- R8: Pattern 4'hF never produces a request, whatever the mask state.
- R9: A group whose encoded-mode enable is 0 or whose upstream mask is 1 forwards no request, whatever its mask bits are.
- R10: Writes to any address other than 4'h0 and 4'h4 leave all mask bits unchanged, and reads of such addresses return 32'h0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| grp_pat | input | 8 | Encoded patterns: group 0 in [3:0], group 1 in [7:4] |
| grp_enc_en | input | 2 | Per-group encoded-mode enable |
| grp_upmask | input | 2 | Per-group upstream mask (1 blocks the group) |
| req_valid | output | 2 | Per-group forwarded request |
| req_pat | output | 8 | Per-group forwarded pattern, same packing as grp_pat |

## Verification
The assertions check on every cycle that set writes make their bits stick, that clear writes empty their bits, and that writes to other addresses leave the mask untouched. They also check, for each group, that a forwarded request never carries the idle pattern, never appears while the group is disabled or blocked, never has its pattern's mask bit set, and always echoes the input pattern. The bench's scenarios are needed to show the image bit positions for each pattern, the reserved bits, the read-back in the cycle after a write, and the reset state. They also sweep every pattern against every enable and upstream combination under several mask states.

// File: rtl/irlmask_pkg.sv
package irlmask_pkg;

    // Byte offsets of the two mask registers
    localparam int OFS_SET = 0;
    localparam int OFS_CLR = 4;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_SET  = 2'd1,
        SEL_CLR  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/irlmask_regs.sv
module irlmask_regs
    import irlmask_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int NGRP   = 2,
    parameter int HALF   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         we,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [NGRP*(HALF-1)-1:0]     mask_flat
);
    localparam int NPAT = HALF - 1;
    localparam int MW   = NGRP * NPAT;

    typedef struct packed {
        logic [MW-1:0] mask;
    } st_t;

    st_t      st_d, st_q;
    reg_sel_e sel;
    logic [MW-1:0]     wr_vec;
    logic [DATA_W-1:0] img;

    always_comb begin
        if (addr == OFS_SET[ADDR_W-1:0])      sel = SEL_SET;
        else if (addr == OFS_CLR[ADDR_W-1:0]) sel = SEL_CLR;
        else                                  sel = SEL_NONE;
    end

    // Map between pattern-indexed storage and the register image
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int BASE = (NGRP - 1 - g) * HALF;
        assign img[BASE] = 1'b0;
        for (genvar p = 0; p < NPAT; p++) begin : g_pat
            localparam int B = BASE + HALF - 1 - p;
            assign wr_vec[g*NPAT + p] = wdata[B];
            assign img[B]             = st_q.mask[g*NPAT + p];
        end
    end

    always_comb begin
        st_d = st_q;
        if (we && sel == SEL_SET) st_d.mask = st_d.mask | wr_vec;
        if (we && sel == SEL_CLR) st_d.mask = st_d.mask & ~wr_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata     = (sel == SEL_SET) ? img : '0;
    assign mask_flat = st_q.mask;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_SET) |=> ((mask_flat & $past(wr_vec)) == $past(wr_vec))); // R2
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_CLR) |=> ((mask_flat & $past(wr_vec)) == '0)); // R3
    AST_OTHER_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || sel == SEL_NONE) |=> $stable(mask_flat)); // R10

endmodule

// File: rtl/irlmask_gate.sv
module irlmask_gate #(
    parameter int PAT_W = 4
) (
    input  logic [PAT_W-1:0]        pat,
    input  logic                    enc_en,
    input  logic                    upmask,
    input  logic [(2**PAT_W)-2:0]   mask_row,
    output logic                    valid,
    output logic [PAT_W-1:0]        pat_o
);
    localparam int HALF = 2 ** PAT_W;
    localparam logic [PAT_W-1:0] IDLE = '1;

    logic [HALF-1:0] row_ext;
    logic            pat_masked;

    // Idle pattern is treated as permanently masked
    assign row_ext    = {1'b1, mask_row};
    assign pat_masked = row_ext[pat];

    always_comb begin
        valid = enc_en && !upmask && !pat_masked;
        pat_o = valid ? pat : IDLE;
    end

endmodule

// File: rtl/irlmask_top.sv
module irlmask_top
    import irlmask_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int PAT_W  = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic                                  bus_we,
    input  logic [DATA_W-1:0]                     bus_wdata,
    output logic [DATA_W-1:0]                     bus_rdata,
    input  logic [(DATA_W/(2**PAT_W))*PAT_W-1:0]  grp_pat,
    input  logic [(DATA_W/(2**PAT_W))-1:0]        grp_enc_en,
    input  logic [(DATA_W/(2**PAT_W))-1:0]        grp_upmask,
    output logic [(DATA_W/(2**PAT_W))-1:0]        req_valid,
    output logic [(DATA_W/(2**PAT_W))*PAT_W-1:0]  req_pat
);
    localparam int HALF = 2 ** PAT_W;
    localparam int NPAT = HALF - 1;
    localparam int NGRP = DATA_W / HALF;

    logic [NGRP*NPAT-1:0] mask_flat;

    irlmask_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .NGRP   (NGRP),
        .HALF   (HALF)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .mask_flat (mask_flat)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_gate
        logic [HALF-1:0] chk_row;

        irlmask_gate #(.PAT_W(PAT_W)) u_gate (
            .pat      (grp_pat[g*PAT_W +: PAT_W]),
            .enc_en   (grp_enc_en[g]),
            .upmask   (grp_upmask[g]),
            .mask_row (mask_flat[g*NPAT +: NPAT]),
            .valid    (req_valid[g]),
            .pat_o    (req_pat[g*PAT_W +: PAT_W])
        );

        assign chk_row = {1'b0, mask_flat[g*NPAT +: NPAT]};

        AST_NO_IDLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[g] |-> (grp_pat[g*PAT_W +: PAT_W] != '1)); // R8
        AST_GROUP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (!grp_enc_en[g] || grp_upmask[g]) |-> !req_valid[g]); // R9
        AST_MASK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[g] |-> !chk_row[grp_pat[g*PAT_W +: PAT_W]]); // R7
        AST_PAT_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[g] |-> (req_pat[g*PAT_W +: PAT_W] == grp_pat[g*PAT_W +: PAT_W])); // R7
    end

endmodule

// File: tb/sim_irlmask_top.sv
module sim_irlmask_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  grp_pat = '0;
    logic [1:0]  grp_enc_en = '0;
    logic [1:0]  grp_upmask = '0;
    logic [1:0]  req_valid;
    logic [7:0]  req_pat;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    logic [31:0] model = '0;
    localparam logic [31:0] VALID_BITS = 32'hFFFE_FFFE;

    always #10 clk = ~clk;

    irlmask_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .grp_pat(grp_pat),
        .grp_enc_en(grp_enc_en), .grp_upmask(grp_upmask),
        .req_valid(req_valid), .req_pat(req_pat)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        if (a == 4'h0)      model = model | (d & VALID_BITS);
        else if (a == 4'h4) model = model & ~d;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #2;
        check(tag, bus_rdata, exp);
    endtask

    function automatic logic [4:0] exp_req(input logic [31:0] m, input int g,
                                           input logic [3:0] p, input logic en, input logic up);
        if (p == 4'hF || !en || up) return {1'b0, 4'hF};
        if (m[(1 - g) * 16 + 15 - int'(p)]) return {1'b0, 4'hF};
        return {1'b1, p};
    endfunction

    task automatic sweep(input string tag);
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 16; p++) begin
                grp_enc_en = c[1:0];
                grp_upmask = c[3:2];
                grp_pat    = {p[3:0], p[3:0]};
                #2;
                for (int g = 0; g < 2; g++) begin
                    check($sformatf("R7/R8/R9 %s g%0d p%0d c%0d", tag, g, p, c),
                          {27'd0, req_valid[g], req_pat[g*4 +: 4]},
                          {27'd0, exp_req(model, g, p[3:0], c[g], c[g+2])});
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(4'h0, 32'h0, "R1 mask image after reset");
        rd(4'h4, 32'h0, "R3 clear reg reads zero");
        grp_enc_en = 2'b11; grp_pat = 8'h52; #2;
        check("R1 requests pass after reset", {24'd0, req_valid, req_pat[7:4], req_pat[3:0]},
              {24'd0, 2'b11, 4'h5, 4'h2});
        sweep("reset");
        // R2/R5/R6
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, 32'hFFFE_FFFE, "R5/R6 set all, reserved bits stay 0");
        wr(4'h4, 32'h0);
        rd(4'h0, 32'hFFFE_FFFE, "R3 clear write of zero has no effect");
        rd(4'h4, 32'h0, "R3 clear reg reads zero when masks set");
        wr(4'h0, 32'h0);
        rd(4'h0, 32'hFFFE_FFFE, "R2 set write of zero has no effect");
        sweep("all_masked");
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h0, 32'h0, "R3/R6 clear all");
        // R10: other addresses
        for (int a = 0; a < 16; a++) begin
            if (a != 0 && a != 4) begin
                wr(a[3:0], 32'hFFFF_FFFF);
                rd(4'h0, 32'h0, $sformatf("R10 write to addr %0h ignored", a));
                rd(a[3:0], 32'h0, $sformatf("R10 read of addr %0h is zero", a));
            end
        end
        // R4: single-bit placement
        wr(4'h0, 32'h0000_1000);
        rd(4'h0, 32'h0000_1000, "R4 group1 pattern 3 at bit 12");
        grp_enc_en = 2'b11; grp_upmask = 2'b00; grp_pat = 8'h33; #2;
        check("R4 group1 p3 blocked, group0 p3 passes", {30'd0, req_valid}, {30'd0, 2'b01});
        wr(4'h0, 32'h8000_0000);
        grp_pat = 8'h00; #2;
        check("R4 group0 pattern 0 at bit 31", {30'd0, req_valid}, {30'd0, 2'b10});
        wr(4'h4, 32'hFFFF_FFFF);
        // R2/R3/R6 mixed set/clear sequence
        for (int i = 1; i <= 24; i++) begin
            logic [31:0] d;
            d = 32'h9E37_79B9 * i ^ (32'h0000_F00D << (i % 13));
            wr((i % 3 == 0) ? 4'h4 : 4'h0, d);
            rd(4'h0, model, $sformatf("R2/R3/R6 step %0d", i));
            if (i == 12) sweep("mixed");
        end
        sweep("final");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule